// File: doc/BRIEF.md
# Pause Loop Filter Counter

This block watches pause events from a guest execution engine and decides when a tight spin loop has run long enough to warrant an intercept exit. At the start of guest execution a load strobe copies a programmed pause budget into an internal signed counter. Every later pause is judged by how many idle cycles came before it. A pause that follows a long gap refills the budget. A pause that follows a short gap spends one unit of the budget. When a short-spaced pause finds the budget already used up and intercepts are enabled, the block fires a one-cycle exit pulse and then ignores further pauses until the next load.

A 16-bit cycle threshold sets the boundary between long and short gaps. A threshold of zero turns spacing detection off, and every pause spends budget, giving a plain countdown. Gaps are measured by a saturating elapsed-cycle timer that is one bit wider than the threshold. Any gap too long for the timer to count therefore still reads as longer than every possible threshold.

Top module: `pause_filter`

## Requirements
- R1: A cycle with `load_i` high copies `count_cfg_i` into the pause counter, clears the halted state and leaves `exit_o` low in the following cycle.
- R2: The gap of a pause is the number of cycles between it and the previous pause cycle or load cycle in which neither `pause_i` nor `load_i` was high. Back-to-back pause cycles have a gap of 0.
- R3: With a non-zero threshold, a pause whose gap is strictly greater than `thresh_i` reloads the counter from `count_cfg_i` and never raises `exit_o`.
- R4: A pause whose gap is less than or equal to `thresh_i` decrements the counter by one when the counter is positive.
- R5: A decrementing pause that finds the counter at zero or below sets the counter to -1. If `icpt_en_i` is high in that cycle, `exit_o` is high for exactly the one cycle after that pause.
- R6: With `thresh_i` equal to 0, every pause decrements, whatever its gap. With `count_cfg_i` = N and intercepts enabled, the exit follows pause number N+1.
- R7: After an exit, pauses change neither the counter nor `exit_o` until the next load.
- R8: With `icpt_en_i` low, no exit is raised and the counter stays at -1 through further short pauses. A wide pause still reloads it, and a short pause made after enabling intercepts exits at once.
- R9: The elapsed timer saturates rather than wraps. A gap of any length, even beyond the timer's range, counts as greater than a threshold of 65535.
- R10: A pause in the same cycle as a load is ignored, and the load takes effect alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Guest entry strobe: loads the budget and restarts the gap timer |
| count_cfg_i | input | CNT_W | Programmed pause budget |
| thresh_i | input | THR_W | Gap threshold in cycles, 0 selects countdown only |
| icpt_en_i | input | 1 | Intercept enable |
| pause_i | input | 1 | One pause event per high cycle |
| exit_o | output | 1 | One-cycle intercept exit pulse |

## Verification
The bench aims at the gap that equals the threshold exactly. A design that used a strict less-than test would refill there and never exit. It runs a gap of 140000 idle cycles against the largest threshold. A wrapping timer would read a small gap, drain the budget and exit, where a saturating one refills. It checks that a pause sharing a cycle with a load is dropped, that the counter clamps at -1 while intercepts are disabled and exits as soon as they are enabled, and that pauses after an exit stay silent. A design with any of these wrong would exit early, exit late, exit twice, or stay silent when it should fire.

// File: rtl/pf_pkg.sv
package pf_pkg;
   // Verdict on a single pause event
   typedef enum logic [1:0] {
      PF_IGNORE = 2'd0,
      PF_REFILL = 2'd1,
      PF_DRAIN  = 2'd2
   } pf_act_e;
endpackage

// File: rtl/pf_gap_timer.sv
module pf_gap_timer #(
   parameter int ELAP_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   output logic [ELAP_W-1:0] elapsed_o
);
   localparam logic [ELAP_W-1:0] ELAP_MAX = '1;

   logic [ELAP_W-1:0] elap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                elap_q <= '0;
      else if (clr_i)            elap_q <= '0;
      else if (elap_q != ELAP_MAX) elap_q <= elap_q + 1'b1;
   end

   assign elapsed_o = elap_q;

   assert_gap_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> elapsed_o == '0);
   assert_gap_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && elapsed_o != ELAP_MAX) |=> elapsed_o == $past(elapsed_o) + 1'b1);
   assert_gap_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && elapsed_o == ELAP_MAX) |=> elapsed_o == ELAP_MAX);
endmodule

// File: rtl/pf_spacing_judge.sv
module pf_spacing_judge
   import pf_pkg::*;
#(
   parameter int THR_W      = 16,
   parameter int ELAP_W     = 17,
   parameter bit USE_THRESH = 1'b1
) (
   input  logic              pause_i,
   input  logic              load_i,
   input  logic              halted_i,
   input  logic [ELAP_W-1:0] elapsed_i,
   input  logic [THR_W-1:0]  thresh_i,
   output pf_act_e           act_o
);
   logic wide;

   generate
      if (USE_THRESH) begin : g_spacing
         assign wide = (thresh_i != '0) && (elapsed_i > ELAP_W'(thresh_i));
      end else begin : g_count_only
         logic unused_inputs;
         assign unused_inputs = ^{elapsed_i, thresh_i};
         assign wide = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!pause_i || load_i || halted_i) act_o = PF_IGNORE;
      else if (wide)                      act_o = PF_REFILL;
      else                                act_o = PF_DRAIN;
   end
endmodule

// File: rtl/pf_pause_counter.sv
module pf_pause_counter
   import pf_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] count_cfg_i,
   input  logic             icpt_en_i,
   input  pf_act_e          act_i,
   output logic             halted_o,
   output logic             exit_o
);
   localparam int SW = CNT_W + 1;

   logic signed [SW-1:0] cnt_q;
   logic                 halted_q;
   logic                 exit_q;
   logic                 spent;

   assign spent = cnt_q[SW-1] || (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         halted_q <= 1'b0;
         exit_q   <= 1'b0;
      end else begin
         exit_q <= 1'b0;
         if (load_i) begin
            cnt_q    <= $signed({1'b0, count_cfg_i});
            halted_q <= 1'b0;
         end else begin
            case (act_i)
               PF_REFILL: cnt_q <= $signed({1'b0, count_cfg_i});
               PF_DRAIN: begin
                  if (spent) begin
                     cnt_q <= '1;
                     if (icpt_en_i) begin
                        exit_q   <= 1'b1;
                        halted_q <= 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign halted_o = halted_q;
   assign exit_o   = exit_q;

   assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $signed({1'b0, $past(count_cfg_i)})) && !halted_q && !exit_q);
   assert_refill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && act_i == PF_REFILL) |=> !exit_q && cnt_q == $signed({1'b0, $past(count_cfg_i)}));
   assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && act_i == PF_DRAIN && !spent) |=> cnt_q == $past(cnt_q) - 1 && !exit_q);
   assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exit_q |=> !exit_q);
   assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_q && !load_i) |=> $stable(cnt_q) && !exit_q);
   assert_no_exit_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !icpt_en_i |=> !exit_q);
endmodule

// File: rtl/pause_filter.sv
module pause_filter
   import pf_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int THR_W      = 16,
   parameter int ELAP_W     = THR_W + 1,
   parameter bit USE_THRESH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] count_cfg_i,
   input  logic [THR_W-1:0] thresh_i,
   input  logic             icpt_en_i,
   input  logic             pause_i,
   output logic             exit_o
);
   initial begin
      chk_elap_width: assert (ELAP_W > THR_W)
         else $error("elapsed timer must be wider than the threshold");
      chk_cnt_width: assert (CNT_W >= 1)
         else $error("pause budget width must be positive");
   end

   logic [ELAP_W-1:0] elapsed;
   logic              halted;
   pf_act_e           act;

   pf_gap_timer #(.ELAP_W(ELAP_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (pause_i | load_i),
      .elapsed_o (elapsed)
   );

   pf_spacing_judge #(
      .THR_W      (THR_W),
      .ELAP_W     (ELAP_W),
      .USE_THRESH (USE_THRESH)
   ) u_judge (
      .pause_i   (pause_i),
      .load_i    (load_i),
      .halted_i  (halted),
      .elapsed_i (elapsed),
      .thresh_i  (thresh_i),
      .act_o     (act)
   );

   pf_pause_counter #(.CNT_W(CNT_W)) u_counter (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load_i),
      .count_cfg_i (count_cfg_i),
      .icpt_en_i   (icpt_en_i),
      .act_i       (act),
      .halted_o    (halted),
      .exit_o      (exit_o)
   );

   assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && pause_i) |=> !exit_o);
   assert_count_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_i && !load_i && !halted && thresh_i == '0) |-> act != PF_REFILL);
endmodule

// File: tb/pause_filter_test.sv
module pause_filter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic [15:0] count_cfg_i = '0;
   logic [15:0] thresh_i = '0;
   logic        icpt_en_i = 1'b0;
   logic        pause_i = 1'b0;
   logic        exit_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   pause_filter uut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .count_cfg_i(count_cfg_i),
      .thresh_i(thresh_i), .icpt_en_i(icpt_en_i), .pause_i(pause_i), .exit_o(exit_o)
   );

   always #10 clk = ~clk;

   // budget, threshold, enable, pause count, gap, index of exiting pause (0 = none), requirement
   localparam int NV = 7;
   localparam int V_CFG [NV] = '{3, 3, 3, 0, 2, 2, 5};
   localparam int V_THR [NV] = '{10, 10, 10, 5, 0, 8, 1};
   localparam int V_EN  [NV] = '{1, 1, 1, 1, 1, 0, 1};
   localparam int V_NUM [NV] = '{6, 6, 6, 2, 5, 6, 8};
   localparam int V_GAP [NV] = '{2, 11, 10, 0, 200, 1, 1};
   localparam int V_EXP [NV] = '{4, 0, 4, 1, 3, 0, 6};
   localparam string V_REQ [NV] = '{"R4", "R3", "R4", "R5", "R6", "R8", "R2"};

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_load(input int cfg, input int thr, input int en, input bit with_pause);
      load_i = 1'b1;
      count_cfg_i = 16'(cfg);
      thresh_i = 16'(thr);
      icpt_en_i = en[0];
      pause_i = with_pause;
      @(negedge clk);
      load_i = 1'b0;
      pause_i = 1'b0;
      chk(exit_o == 1'b0, "R1", int'(exit_o), 0);
   endtask

   task automatic pause_after(input int gap, output logic ex);
      repeat (gap) @(negedge clk);
      pause_i = 1'b1;
      @(negedge clk);
      pause_i = 1'b0;
      ex = exit_o;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 195000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            report();
         end
      end
   end

   initial begin
      logic ex;
      repeat (3) @(negedge clk);
      chk(exit_o == 1'b0, "R1", int'(exit_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(exit_o == 1'b0, "R1", int'(exit_o), 0);

      // Vector table
      for (int v = 0; v < NV; v++) begin
         do_load(V_CFG[v], V_THR[v], V_EN[v], 1'b0);
         for (int p = 1; p <= V_NUM[v]; p++) begin
            pause_after(V_GAP[v], ex);
            chk(ex == (p == V_EXP[v]), V_REQ[v], int'(ex), int'(p == V_EXP[v]));
         end
      end

      // R10: pause together with load is dropped; R5 single pulse; R7 silence afterwards
      do_load(0, 8, 1, 1'b1);
      pause_after(0, ex);
      chk(ex == 1'b1, "R10", int'(ex), 1);
      @(negedge clk);
      chk(exit_o == 1'b0, "R5", int'(exit_o), 0);
      for (int p = 0; p < 3; p++) begin
         pause_after(0, ex);
         chk(ex == 1'b0, "R7", int'(ex), 0);
      end

      // R8: disabled intercepts clamp the counter, enabling exits at once
      do_load(1, 8, 0, 1'b0);
      for (int p = 0; p < 3; p++) begin
         pause_after(1, ex);
         chk(ex == 1'b0, "R8", int'(ex), 0);
      end
      icpt_en_i = 1'b1;
      pause_after(1, ex);
      chk(ex == 1'b1, "R8", int'(ex), 1);

      // R8: wide pause refills a negative counter
      do_load(1, 8, 0, 1'b0);
      pause_after(1, ex);
      pause_after(1, ex);
      chk(ex == 1'b0, "R8", int'(ex), 0);
      icpt_en_i = 1'b1;
      pause_after(9, ex);
      chk(ex == 1'b0, "R3", int'(ex), 0);
      pause_after(1, ex);
      chk(ex == 1'b0, "R4", int'(ex), 0);
      pause_after(1, ex);
      chk(ex == 1'b1, "R5", int'(ex), 1);

      // R9: a gap past the timer range still reads as wide
      do_load(0, 65535, 1, 1'b0);
      pause_after(140000, ex);
      chk(ex == 1'b0, "R9", int'(ex), 0);
      pause_after(0, ex);
      chk(ex == 1'b1, "R9", int'(ex), 1);

      report();
   end
endmodule